// File: doc/BRIEF.md
# Tree Prefix Summer

This block computes inclusive prefix sums of N operands of W bits each, with N a power of two. The operands sit in the leaves of a complete binary tree of registered nodes. A small sequencer drives the tree through four phases:

- An upward reduction phase.
- A sibling fix-up phase on the leaf pairs.
- A swap phase. In this phase each internal right child takes its left sibling's partial sum, and the left sibling is set to zero.
- A downward phase. In this phase each node adds its parent's value into its own, one depth per cycle.

When the last phase ends, leaf i holds the sum of operands 0 through i, modulo 2^W.

To use the block, place N operands on the flat operand bus and pulse start while the block is idle. Every leaf is written on that edge. A fixed number of cycles later, a one-cycle done pulse marks the results on the flat result bus as final. The results then stay unchanged until the next accepted start. A start that arrives while the block is busy has no effect.

Top module: `tpa_prefix_tree`

## Requirements
- R1: After reset, done_o is low and every result slot of sum_o reads zero.
- R2: A start_i sampled high while the block is idle writes all N operands into the leaves on that same clock edge.
- R3: done_o is high for exactly one cycle. It rises on the (2·log2 N + 2)-th rising edge after the edge that sampled an accepted start (8 edges for N = 8).
- R4: A start_i sampled while the block is busy is ignored. It causes no reload and no restart, and it changes neither the results nor the timing of done_o.
- R5: While the block is idle and no start is accepted, sum_o stays unchanged. This covers the span from the done pulse until the next accepted start.
- R6: After done_o rises, slot i of sum_o (bits [i·W +: W]) equals the sum of operand slots 0 through i of opnd_i (bits [j·W +: W]) as they were when start was accepted.
- R7: The phases run in a fixed order and length:
  - upward for log2 N − 1 cycles;
  - leaf-pair fix-up for 2 cycles;
  - swap for 2 cycles;
  - downward for log2 N − 1 cycles.
- R8: In each upward cycle, every node at the addressed depth takes the sum of its two children. The depth starts just above the leaves and moves up to depth one.
- R9: In the fix-up phase, every right leaf becomes the sum of its left sibling and itself, and every left leaf keeps its value.
- R10: In the swap phase, every internal right child takes its left sibling's value, and every internal left child becomes zero.
- R11: In each downward cycle, every node at the addressed depth adds its parent's value to its own. The depth starts at two and moves down to the leaves.
- R12: All additions wrap modulo 2^W.
- R13: A start_i sampled in the cycle where done_o is high is accepted as a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start_i | input | 1 | Start pulse; accepted only while idle |
| opnd_i | input | N·W | Operands; slot i at bits [i·W +: W] |
| done_o | output | 1 | One-cycle pulse when the results are final |
| sum_o | output | N·W | Inclusive prefix sums; slot i at bits [i·W +: W] |

## Verification
The bench goes after operands at the top of the range, so that every prefix overflows. A design that widened or saturated its sums would then give wrong upper slots. It fires start pulses in the middle of a run and on the run's last step. A design that reloaded or restarted on them would shift the done pulse or mix in the newer operands. It also starts a new run in the very cycle done is high, which a sequencer with an extra idle cycle would drop. Sequential and random operand sets catch a wrong sibling pairing, a missed clear of a left sibling, or a downward pass that skips a depth, because each of these corrupts particular slots but not all of them.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  // Sequencer phases of the tree.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_UP   = 3'd1,
    PH_PAIR = 3'd2,
    PH_SWAP = 3'd3,
    PH_DOWN = 3'd4
  } tpa_phase_e;

endpackage

// File: rtl/tpa_ctrl.sv
module tpa_ctrl
  import tpa_pkg::*;
#(
  parameter int LVLS = 3,
  parameter int CW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output tpa_phase_e       phase_o,
  output logic             sub_o,
  output logic [CW-1:0]    lvl_o,
  output logic             load_o,
  output logic             idle_o,
  output logic             done_o
);

  localparam int LAST_UD = (LVLS > 1) ? LVLS - 2 : 0;

  tpa_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          adv;
  logic          load;

  // Next-state logic.
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    load   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          load  = 1'b1;
          cnt_d = '0;
          ph_d  = (LVLS > 1) ? PH_UP : PH_PAIR;
        end
      end
      PH_UP: begin
        if (cnt_q == CW'(LAST_UD)) begin
          ph_d  = PH_PAIR;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_PAIR: begin
        if (cnt_q == CW'(1)) begin
          ph_d  = PH_SWAP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_SWAP: begin
        if (cnt_q == CW'(1)) begin
          cnt_d = '0;
          if (LVLS > 1) begin
            ph_d = PH_DOWN;
          end else begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_DOWN: begin
        if (cnt_q == CW'(LAST_UD)) begin
          ph_d   = PH_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign adv = (ph_q != PH_IDLE) || start_i;

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (adv) begin
        ph_q  <= ph_d;
        cnt_q <= cnt_d;
      end
      done_q <= done_d;
    end
  end

  // Depth addressed by the upward and downward passes.
  always_comb begin
    lvl_o = '0;
    if (ph_q == PH_UP)   lvl_o = CW'(LVLS - 1) - cnt_q;
    if (ph_q == PH_DOWN) lvl_o = cnt_q + CW'(2);
  end

  assign phase_o = ph_q;
  assign sub_o   = cnt_q[0];
  assign load_o  = load;
  assign idle_o  = (ph_q == PH_IDLE);
  assign done_o  = done_q;

  // R3: done is a single-cycle pulse.
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: done only follows a busy cycle.
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(ph_q) != PH_IDLE);

  // R7: the fix-up phase lasts two cycles and hands over to the swap phase.
  p_pair_to_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PAIR && cnt_q == CW'(1)) |=> ph_q == PH_SWAP);

  // R7: the upward phase only moves on to the fix-up phase.
  p_up_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UP) |=> (ph_q == PH_UP || ph_q == PH_PAIR));

  // R4: a busy sequencer never asks for a reload.
  p_busy_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> !(ph_q == PH_UP && cnt_q == '0 && $past(ph_q) == PH_UP));

endmodule

// File: rtl/tpa_inner.sv
module tpa_inner
  import tpa_pkg::*;
#(
  parameter int W        = 16,
  parameter int CW       = 3,
  parameter int DEPTH    = 1,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tpa_phase_e    phase_i,
  input  logic          sub_i,
  input  logic [CW-1:0] lvl_i,
  input  logic [W-1:0]  lc_i,
  input  logic [W-1:0]  rc_i,
  input  logic [W-1:0]  sib_i,
  input  logic [W-1:0]  par_i,
  output logic [W-1:0]  val_o
);

  logic [W-1:0] val_q, val_d, msg_q, msg_d;
  logic         val_en, msg_en;
  logic         my_lvl;

  assign my_lvl = (lvl_i == CW'(DEPTH));

  // Next-value logic.
  always_comb begin
    val_en = 1'b0;
    val_d  = val_q;
    msg_en = 1'b0;
    msg_d  = msg_q;
    case (phase_i)
      PH_UP: begin
        if (my_lvl) begin
          val_en = 1'b1;
          val_d  = lc_i + rc_i;
        end
      end
      PH_SWAP: begin
        if (IS_RIGHT) begin
          if (!sub_i) begin
            msg_en = 1'b1;
            msg_d  = sib_i;
          end else begin
            val_en = 1'b1;
            val_d  = msg_q;
          end
        end else if (sub_i) begin
          val_en = 1'b1;
          val_d  = '0;
        end
      end
      PH_DOWN: begin
        if (my_lvl) begin
          val_en = 1'b1;
          val_d  = val_q + par_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      msg_q <= '0;
    end else begin
      if (val_en) val_q <= val_d;
      if (msg_en) msg_q <= msg_d;
    end
  end

  assign val_o = val_q;

  // R8: an upward step at this depth leaves the children's sum.
  p_up_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_UP && lvl_i == CW'(DEPTH)) |=> val_q == W'($past(lc_i) + $past(rc_i)));

  // R10: a left child is cleared by the swap.
  p_clear_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_RIGHT && phase_i == PH_SWAP && sub_i) |=> val_q == '0);

  // R10: a right child ends the swap with its sibling's value.
  p_take_sib_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_RIGHT && phase_i == PH_SWAP && sub_i) |=> val_q == $past(sib_i));

  // R11: a downward step at this depth adds the parent's value.
  p_down_add_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DOWN && lvl_i == CW'(DEPTH)) |=> val_q == W'($past(val_q) + $past(par_i)));

endmodule

// File: rtl/tpa_leaf.sv
module tpa_leaf
  import tpa_pkg::*;
#(
  parameter int W        = 16,
  parameter int CW       = 3,
  parameter int LVLS     = 3,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          idle_i,
  input  tpa_phase_e    phase_i,
  input  logic          sub_i,
  input  logic [CW-1:0] lvl_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [W-1:0]  sib_i,
  input  logic [W-1:0]  par_i,
  output logic [W-1:0]  val_o
);

  logic [W-1:0] val_q, val_d, msg_q, msg_d;
  logic         val_en, msg_en;

  // Next-value logic.
  always_comb begin
    val_en = 1'b0;
    val_d  = val_q;
    msg_en = 1'b0;
    msg_d  = msg_q;
    if (load_i) begin
      val_en = 1'b1;
      val_d  = opnd_i;
    end else begin
      case (phase_i)
        PH_PAIR: begin
          if (IS_RIGHT) begin
            if (!sub_i) begin
              msg_en = 1'b1;
              msg_d  = sib_i;
            end else begin
              val_en = 1'b1;
              val_d  = val_q + msg_q;
            end
          end
        end
        PH_DOWN: begin
          if (lvl_i == CW'(LVLS)) begin
            val_en = 1'b1;
            val_d  = val_q + par_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      msg_q <= '0;
    end else begin
      if (val_en) val_q <= val_d;
      if (msg_en) msg_q <= msg_d;
    end
  end

  assign val_o = val_q;

  // R2: the operand is captured on the load edge.
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> val_q == $past(opnd_i));

  // R5: an idle leaf holds its result.
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !load_i) |=> $stable(val_q));

  // R9: a left leaf is untouched by the fix-up phase.
  p_left_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_RIGHT && phase_i == PH_PAIR) |=> $stable(val_q));

  // R9: a right leaf ends the fix-up phase as the sum of the pair.
  p_pair_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_RIGHT && phase_i == PH_PAIR && sub_i) |=> val_q == W'($past(val_q) + $past(sib_i)));

  // R11: a downward step at leaf depth adds the parent's value.
  p_down_add_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DOWN && lvl_i == CW'(LVLS)) |=> val_q == W'($past(val_q) + $past(par_i)));

endmodule

// File: rtl/tpa_prefix_tree.sv
module tpa_prefix_tree
  import tpa_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N*W-1:0] opnd_i,
  output logic         done_o,
  output logic [N*W-1:0] sum_o
);

  localparam int LVLS  = $clog2(N);
  localparam int CW    = $clog2(LVLS + 2);
  localparam int NODES = 2 * N - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tpa_phase_e    phase;
  logic          sub;
  logic [CW-1:0] lvl;
  logic          load, idle, done;

  tpa_ctrl #(.LVLS(LVLS), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync),
    .start_i (start_i),
    .phase_o (phase),
    .sub_o   (sub),
    .lvl_o   (lvl),
    .load_o  (load),
    .idle_o  (idle),
    .done_o  (done)
  );

  // Node k (1-based, heap order) lives at bits [(k-1)*W +: W].
  logic [NODES*W-1:0] nv;

  // The root is never used; it stands in as a zero parent.
  assign nv[0 +: W] = '0;

  genvar k;
  generate
    for (k = 2; k < N; k++) begin : g_inner
      localparam int DEP = $clog2(k + 1) - 1;
      localparam int SIB = k ^ 1;
      tpa_inner #(
        .W(W), .CW(CW), .DEPTH(DEP), .IS_RIGHT((k % 2) == 1)
      ) u_node (
        .clk     (clk),
        .rst_n   (rst_sync),
        .phase_i (phase),
        .sub_i   (sub),
        .lvl_i   (lvl),
        .lc_i    (nv[(2*k-1)*W +: W]),
        .rc_i    (nv[(2*k)*W +: W]),
        .sib_i   (nv[(SIB-1)*W +: W]),
        .par_i   (nv[(k/2-1)*W +: W]),
        .val_o   (nv[(k-1)*W +: W])
      );
    end

    for (k = N; k < 2 * N; k++) begin : g_leaf
      localparam int SIB = k ^ 1;
      tpa_leaf #(
        .W(W), .CW(CW), .LVLS(LVLS), .IS_RIGHT((k % 2) == 1)
      ) u_leaf (
        .clk     (clk),
        .rst_n   (rst_sync),
        .load_i  (load),
        .idle_i  (idle),
        .phase_i (phase),
        .sub_i   (sub),
        .lvl_i   (lvl),
        .opnd_i  (opnd_i[(k-N)*W +: W]),
        .sib_i   (nv[(SIB-1)*W +: W]),
        .par_i   (nv[(k/2-1)*W +: W]),
        .val_o   (nv[(k-1)*W +: W])
      );
    end
  endgenerate

  assign sum_o  = nv[(N-1)*W +: N*W];
  assign done_o = done;

  // R13: starting in the done cycle launches a new run at once.
  p_restart_on_done_r13: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && start_i) |=> !idle);

endmodule

// File: tb/sim_tpa_prefix_tree.sv
module sim_tpa_prefix_tree;

  localparam int N     = 8;
  localparam int W     = 16;
  localparam int LV    = $clog2(N);
  localparam int TOTAL = 2 * LV + 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [N*W-1:0] opnd;
  logic           done;
  logic [N*W-1:0] sums;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    cyc    = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  tpa_prefix_tree #(.N(N), .W(W)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .opnd_i  (opnd),
    .done_o  (done),
    .sum_o   (sums)
  );

  // Behavioural prefix sum, R6 and R12: wraps modulo 2^W.
  function automatic logic [N*W-1:0] prefix_of(logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    int acc;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      acc = (acc + int'(v[i*W +: W])) % (1 << W);
      r[i*W +: W] = W'(acc);
    end
    return r;
  endfunction

  // Cycle model: a countdown that accepts start only at zero (R4, R13).
  int             mcnt;
  logic           exp_done;
  logic [N*W-1:0] pend, exp_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt     <= 0;
      exp_done <= 1'b0;
      pend     <= '0;
      exp_vec  <= '0;
    end else begin
      exp_done <= 1'b0;
      if (mcnt == 0) begin
        if (start) begin
          mcnt <= TOTAL;
          pend <= prefix_of(opnd);
        end
      end else begin
        mcnt <= mcnt - 1;
        if (mcnt == 1) begin
          exp_done <= 1'b1;
          exp_vec  <= pend;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (done !== exp_done) begin
        n_bad++;
        $display("FAIL R3 done: actual %b expected %b (cycle %0d)", done, exp_done, cyc);
      end
      if (mcnt == 0) begin
        n_cmp++;
        if (sums !== exp_vec) begin
          n_bad++;
          $display("FAIL %s sums: actual %h expected %h (cycle %0d)", cur_tag, sums, exp_vec, cyc);
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic launch(input logic [N*W-1:0] v, input string tag);
    @(negedge clk);
    opnd    = v;
    start   = 1'b1;
    cur_tag = tag;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_one(input logic [N*W-1:0] v, input string tag);
    launch(v, tag);
    repeat (TOTAL + 2) @(negedge clk);
  endtask

  function automatic logic [N*W-1:0] seq_vec(int base);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(base + i);
    return r;
  endfunction

  function automatic logic [N*W-1:0] rnd_vec();
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    opnd  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports.
    n_cmp++;
    if (done !== 1'b0 || sums !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: actual done %b sums %h expected 0 and 0", done, sums);
    end

    // R2 R6 R8 R9 R10 R11: operands 1..N give triangular numbers.
    run_one(seq_vec(1), "R2 R6 R8 R9 R10 R11");

    // R5: results hold while idle.
    cur_tag = "R5";
    repeat (10) @(negedge clk);

    // Single non-zero operand at each position.
    for (int p = 0; p < N; p++) begin
      logic [N*W-1:0] v;
      v = '0;
      v[p*W +: W] = W'(p + 3);
      run_one(v, "R6 R10 R11");
    end

    // R12: every prefix overflows.
    run_one({N{W'(16'hFFFF)}}, "R12");
    run_one({N{W'(16'h8001)}}, "R12");

    // R4: starts while busy, one mid-run and one on the last step.
    launch(seq_vec(100), "R4");
    @(negedge clk);
    opnd  = rnd_vec();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (TOTAL - 4) @(negedge clk);
    opnd  = seq_vec(500);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);

    // R13: a start in the done cycle is taken.
    launch(seq_vec(7), "R13");
    for (int t = 0; t < 4 * TOTAL && !done; t++) @(negedge clk);
    opnd  = seq_vec(40);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (TOTAL + 3) @(negedge clk);

    // Random operand sets.
    for (int r = 0; r < 8; r++) run_one(rnd_vec(), "R6 R12");

    cur_tag = "R5";
    repeat (6) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule